// File: doc/BRIEF.md
# Sixteen-Entry LRU Lookup CAM

This block is a small content-addressable tag cache placed next to one processing engine. It keeps sixteen 32-bit tags. Each tag has a valid flag and a lock flag. A lookup compares a key against every valid tag in the same cycle. The next cycle it returns one 6-bit status word. That word carries a hit flag, the lock flag of the matching entry, and an entry index. On a hit the index is the matching entry. On a miss it is the least recently used entry, which is the victim for refill. Software can therefore decide between "use this entry" and "refill this entry" from a single read.

Recency is kept in hardware as an ordered list of entry numbers. Hits and tag writes move an entry to the most recent end of the list. Misses and lock updates leave the list alone. The lock flag does not take part in matching or replacement. It is a semaphore that is only reported back in the status word.

Top module: `lru_cam`

## Requirements
- R1: After reset, status_valid_o is low, status_o is 0, every entry is invalid with its lock clear, and the recency order runs from entry 0 (least recent) to entry 15 (most recent).
- R2: A lookup is accepted when lookup_i is high and wr_i is low. status_valid_o is high in exactly the cycle after an accepted lookup. status_o keeps its last value until the next accepted lookup.
- R3: On a hit, status_o[5] is 1 and status_o[3:0] holds the matching entry index. If several valid entries match, the lowest index is reported.
- R4: On a miss, status_o[5] is 0, status_o[4] is 0, and status_o[3:0] holds the current least recently used entry.
- R5: On a hit, status_o[4] equals the lock flag of the matching entry as it stood before that clock edge.
- R6: A hit moves the matching entry to the most recent position. A miss does not change the order, so back-to-back misses name the same victim.
- R7: A tag write (wr_i) stores wr_tag_i in entry wr_idx_i, marks that entry valid and makes it most recent. Its lock flag is kept. A lookup in the same cycle as a write is ignored.
- R8: A lock update (lock_we_i) sets the lock flag of entry lock_idx_i to lock_val_i. It changes neither matching nor recency order. It may share a cycle with a lookup or a write.
- R9: An invalid entry never matches, whatever key is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_i | input | 1 | Lookup request |
| key_i | input | 32 | Lookup key |
| wr_i | input | 1 | Tag write request |
| wr_idx_i | input | 4 | Entry to write |
| wr_tag_i | input | 32 | Tag value to write |
| lock_we_i | input | 1 | Lock flag update |
| lock_idx_i | input | 4 | Entry whose lock changes |
| lock_val_i | input | 1 | New lock value |
| status_valid_o | output | 1 | Status word is fresh this cycle |
| status_o | output | 6 | {hit, lock, entry index} |

## Verification
Directed patterns come first.
- A key of zero right after reset separates "invalid entries never match" from a plain tag compare.
- Filling all entries in index order and then missing twice shows that victims follow write order and that misses leave the order alone.
- Hits on chosen entries followed by a miss show the hit entry leaving the victim slot.
- Duplicate tags expose the lowest-index rule.
- A lock set in the same cycle as a lookup separates pre-edge from post-edge lock reporting.

A long random phase then mixes lookups, writes and lock updates over a small key space, so hits, misses and collisions all occur often. A behavioural model built on a queue is compared against the outputs on every cycle.

// File: rtl/lru_cam_pkg.sv
package lru_cam_pkg;
  localparam int unsigned ENTRIES = 16;
  localparam int unsigned TAG_W   = 32;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);
  localparam int unsigned STAT_W  = IDX_W + 2;

  typedef struct packed {
    logic             hit;
    logic             lock;
    logic [IDX_W-1:0] idx;
  } cam_status_t;
endpackage

// File: rtl/lru_cam_store.sv
module lru_cam_store #(
  parameter int unsigned N     = 16,
  parameter int unsigned TAG_W = 32,
  localparam int unsigned IW   = $clog2(N)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [IW-1:0]           wr_idx_i,
  input  logic [TAG_W-1:0]        wr_tag_i,
  input  logic                    lock_we_i,
  input  logic [IW-1:0]           lock_idx_i,
  input  logic                    lock_val_i,
  output logic [N-1:0][TAG_W-1:0] tags_o,
  output logic [N-1:0]            valid_o,
  output logic [N-1:0]            lock_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tags_o[g]  <= '0;
        valid_o[g] <= 1'b0;
        lock_o[g]  <= 1'b0;
      end else begin
        if (wr_i && wr_idx_i == IW'(g)) begin
          tags_o[g]  <= wr_tag_i;
          valid_o[g] <= 1'b1;
        end
        if (lock_we_i && lock_idx_i == IW'(g)) lock_o[g] <= lock_val_i;
      end
    end
  end
endmodule

// File: rtl/lru_cam_match.sv
module lru_cam_match #(
  parameter int unsigned N     = 16,
  parameter int unsigned TAG_W = 32,
  localparam int unsigned IW   = $clog2(N)
) (
  input  logic [TAG_W-1:0]        key_i,
  input  logic [N-1:0][TAG_W-1:0] tags_i,
  input  logic [N-1:0]            valid_i,
  output logic                    hit_o,
  output logic [IW-1:0]           hit_idx_o
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  // lowest matching index wins
  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit_o     = 1'b1;
        hit_idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lru_cam_order.sv
module lru_cam_order #(
  parameter int unsigned N   = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_idx_i,
  output logic [IW-1:0] lru_idx_o
);
  // slot 0 = least recent, slot N-1 = most recent
  logic [N-1:0][IW-1:0] order_q, order_d;
  logic [IW-1:0]        pos;

  always_comb begin
    pos = '0;
    for (int i = 0; i < N; i++) begin
      if (order_q[i] == touch_idx_i) pos = IW'(i);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    if (g == N - 1) begin : g_top
      assign order_d[g] = touch_idx_i;
    end else begin : g_mid
      assign order_d[g] = (IW'(g) < pos) ? order_q[g] : order_q[g+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) order_q[i] <= IW'(i);
    end else if (touch_i) begin
      order_q <= order_d;
    end
  end

  assign lru_idx_o = order_q[0];
endmodule

// File: rtl/lru_cam.sv
module lru_cam
  import lru_cam_pkg::*;
#(
  parameter int unsigned N    = ENTRIES,
  parameter int unsigned TW   = TAG_W,
  localparam int unsigned IW  = $clog2(N),
  localparam int unsigned SW  = IW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lookup_i,
  input  logic [TW-1:0] key_i,
  input  logic          wr_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [TW-1:0] wr_tag_i,
  input  logic          lock_we_i,
  input  logic [IW-1:0] lock_idx_i,
  input  logic          lock_val_i,
  output logic          status_valid_o,
  output logic [SW-1:0] status_o
);
  logic [N-1:0][TW-1:0] tags;
  logic [N-1:0]         valid, lock;
  logic                 hit;
  logic [IW-1:0]        hit_idx, lru_idx, touch_idx;
  logic                 accept, touch;
  logic [SW-1:0]        status_d, status_q;
  logic                 valid_q;

  lru_cam_store #(.N(N), .TAG_W(TW)) u_store (
    .clk_i, .rst_ni, .wr_i, .wr_idx_i, .wr_tag_i,
    .lock_we_i, .lock_idx_i, .lock_val_i,
    .tags_o(tags), .valid_o(valid), .lock_o(lock)
  );

  lru_cam_match #(.N(N), .TAG_W(TW)) u_match (
    .key_i, .tags_i(tags), .valid_i(valid),
    .hit_o(hit), .hit_idx_o(hit_idx)
  );

  // writes own the cycle; a colliding lookup is dropped
  assign accept    = lookup_i && !wr_i;
  assign touch     = wr_i || (accept && hit);
  assign touch_idx = wr_i ? wr_idx_i : hit_idx;

  lru_cam_order #(.N(N)) u_order (
    .clk_i, .rst_ni, .touch_i(touch), .touch_idx_i(touch_idx),
    .lru_idx_o(lru_idx)
  );

  assign status_d = hit ? {1'b1, lock[hit_idx], hit_idx} : {2'b00, lru_idx};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= accept;
      if (accept) status_q <= status_d;
    end
  end

  assign status_valid_o = valid_q;
  assign status_o       = status_q;
endmodule

// File: rtl/lru_cam_chk.sv
module lru_cam_chk #(
  parameter int unsigned IW = 4,
  parameter int unsigned TW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          lookup_i,
  input logic [TW-1:0] key_i,
  input logic          wr_i,
  input logic [IW-1:0] wr_idx_i,
  input logic [TW-1:0] wr_tag_i,
  input logic          lock_we_i,
  input logic [IW-1:0] lock_idx_i,
  input logic          lock_val_i,
  input logic          status_valid_o,
  input logic [IW+1:0] status_o
);
  a_r2_valid_after_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_i && !wr_i) |=> status_valid_o);

  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lookup_i && !wr_i) |=> !status_valid_o);

  a_r2_status_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lookup_i && !wr_i) |=> $stable(status_o));

  a_r4_miss_lock_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_valid_o && !status_o[IW+1]) |-> !status_o[IW]);

  a_r6_miss_keeps_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_valid_o && !status_o[IW+1] && $past(status_valid_o && !status_o[IW+1]))
      |-> status_o[IW-1:0] == $past(status_o[IW-1:0]));

  a_r7_write_drops_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !status_valid_o);
endmodule

bind lru_cam lru_cam_chk #(.IW(IW), .TW(TW)) u_chk (.*);

// File: tb/tb_lru_cam.sv
`timescale 1ns/1ps
module tb_lru_cam;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup = 1'b0;
  logic [31:0] key = '0;
  logic        wr = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_tag = '0;
  logic        lock_we = 1'b0;
  logic [3:0]  lock_idx = '0;
  logic        lock_val = 1'b0;
  logic        st_valid;
  logic [5:0]  st;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lru_cam dut (
    .clk_i(clk), .rst_ni(rst_n), .lookup_i(lookup), .key_i(key),
    .wr_i(wr), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag),
    .lock_we_i(lock_we), .lock_idx_i(lock_idx), .lock_val_i(lock_val),
    .status_valid_o(st_valid), .status_o(st)
  );

  // behavioural reference
  logic [31:0] m_tag [N];
  bit          m_val [N];
  bit          m_lock[N];
  int          m_order[$];
  bit          e_valid = 0;
  logic [5:0]  e_st = '0;

  task automatic m_touch(int e);
    foreach (m_order[i]) if (m_order[i] == e) begin m_order.delete(i); break; end
    m_order.push_back(e);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_tag[i] = 0; m_val[i] = 0; m_lock[i] = 0; end
      m_order = {};
      for (int i = 0; i < N; i++) m_order.push_back(i);
      e_valid = 0;
      e_st = '0;
    end else begin
      int h;
      h = -1;
      e_valid = lookup && !wr;
      if (e_valid) begin
        for (int i = 0; i < N; i++) if (h < 0 && m_val[i] && m_tag[i] == key) h = i;
        if (h >= 0) e_st = {1'b1, m_lock[h], 4'(h)};
        else        e_st = {2'b00, 4'(m_order[0])};
      end
      if (wr) begin
        m_tag[wr_idx] = wr_tag;
        m_val[wr_idx] = 1;
        m_touch(int'(wr_idx));
      end else if (e_valid && h >= 0) begin
        m_touch(h);
      end
      if (lock_we) m_lock[lock_idx] = lock_val;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (st_valid !== e_valid || (e_valid && st !== e_st)) begin
        errors++;
        $display("FAIL %s: valid=%0b status=%b expected valid=%0b status=%b",
                 !e_valid ? "R2" : (e_st[5] ? "R3" : "R4"), st_valid, st, e_valid, e_st);
      end
    end
  end

  task automatic expect_st(string req, logic [5:0] exp);
    checks++;
    if (st_valid !== 1'b1 || st !== exp) begin
      errors++;
      $display("FAIL %s: valid=%0b status=%b expected valid=1 status=%b", req, st_valid, st, exp);
    end
  endtask

  task automatic do_lookup(logic [31:0] k);
    lookup = 1; key = k;
    @(negedge clk);
    lookup = 0;
  endtask

  task automatic do_write(int idx, logic [31:0] t);
    wr = 1; wr_idx = 4'(idx); wr_tag = t;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic do_lock(int idx, bit v);
    lock_we = 1; lock_idx = 4'(idx); lock_val = v;
    @(negedge clk);
    lock_we = 0;
  endtask

  function automatic logic [31:0] tg(int i);
    return 32'hA500_0000 + 32'(i * 3);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (st_valid !== 1'b0 || st !== 6'd0) begin
      errors++;
      $display("FAIL R1: valid=%0b status=%b expected valid=0 status=000000", st_valid, st);
    end
    rst_n = 1;
    @(negedge clk);

    // R9 / R1: key 0 equals stale reset tags but entries are invalid; victim is entry 0
    do_lookup(32'h0);
    expect_st("R9", 6'b00_0000);

    // R7: fill entries 0..15 in order
    for (int i = 0; i < N; i++) do_write(i, tg(i));
    // R6: two misses name the same victim
    do_lookup(32'hDEAD_BEEF);
    expect_st("R4", 6'b00_0000);
    do_lookup(32'hDEAD_BEE0);
    expect_st("R6", 6'b00_0000);

    // R3: hit entry 0 moves it away from LRU; victim becomes 1
    do_lookup(tg(0));
    expect_st("R3", 6'b10_0000);
    do_lookup(32'h1234_5678);
    expect_st("R6", 6'b00_0001);

    // R7: a lookup colliding with a write is dropped
    lookup = 1; key = tg(5); wr = 1; wr_idx = 4'd1; wr_tag = tg(1);
    @(negedge clk);
    lookup = 0; wr = 0;
    checks++;
    if (st_valid !== 1'b0) begin
      errors++;
      $display("FAIL R7: valid=%0b expected valid=0", st_valid);
    end
    // entry 1 rewritten -> now MRU, victim entry 2
    do_lookup(32'h1234_5679);
    expect_st("R7", 6'b00_0010);

    // R5/R8: lock set in same cycle as lookup reports old value, then new
    lookup = 1; key = tg(9); lock_we = 1; lock_idx = 4'd9; lock_val = 1;
    @(negedge clk);
    lookup = 0; lock_we = 0;
    expect_st("R5", 6'b10_1001);
    do_lookup(tg(9));
    expect_st("R8", 6'b11_1001);
    // R8: lock does not change recency: victim still entry 2
    do_lock(2, 1);
    do_lookup(32'h0BAD_0BAD);
    expect_st("R8", 6'b00_0010);

    // R3: duplicate tag in entries 4 and 12 -> lowest index reported
    do_write(12, tg(4));
    do_lookup(tg(4));
    expect_st("R3", 6'b10_0100);
    do_lock(9, 0);

    // random mix, compared every cycle by the model
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 9);
      lookup   = (r < 6);
      key      = tg($urandom_range(0, 23));
      wr       = (r >= 5 && r < 8);
      wr_idx   = 4'($urandom_range(0, 15));
      wr_tag   = tg($urandom_range(0, 23));
      lock_we  = ($urandom_range(0, 3) == 0);
      lock_idx = 4'($urandom_range(0, 15));
      lock_val = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    lookup = 0; wr = 0; lock_we = 0;
    @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule